// File: doc/BRIEF.md
# Local Memory Access Cycle Timer

This block paces single, non-burst longword accesses from one requester to local memory. A request arrives on a valid/ready channel. It carries an address, a read/write flag, a parity-check enable and 32 bits of write data. The most significant address bit chooses between a ROM region and a DRAM region. When the block takes a request, it latches all of these fields. It then holds a memory strobe high for exactly the number of bus clocks the access needs, and pulses an acknowledge in the last of those clocks. For a read, the data the memory returns appears on the response bus during that acknowledge clock.

Each access has its own length, fixed at the moment the block accepts it. A DRAM access takes its length from its direction and from its parity setting. A ROM access takes its length from a 3-bit configuration code, which covers four to eleven clocks. A write aimed at the ROM region never reaches memory: it ends with an error pulse.

Back-pressure: the block accepts a request only in a clock where both `req_valid` and `req_ready` are high. `req_ready` falls in the clock after an acceptance and stays low until the clock after the access completes. A requester may hold `req_valid` and change its fields while `req_ready` is low. Nothing it presents during that time affects the access in progress.

Top module: `memcyc_timer`

## Requirements
- R1: `req_ready` is high when the block is idle. It is low from the clock after an acceptance up to and including the clock that carries `rsp_ack` or `rsp_err`. Requests presented while it is low are not taken.
- R2: A DRAM write (`req_addr` MSB = 0, `req_write` = 1) holds `mem_strobe` for 3 clocks, and `rsp_ack` falls in the third.
- R3: A DRAM read with `req_parity` = 0 holds `mem_strobe` for 5 clocks, with `rsp_ack` in the fifth.
- R4: A DRAM read with `req_parity` = 1 holds `mem_strobe` for 6 clocks, with `rsp_ack` in the sixth.
- R5: A ROM read (`req_addr` MSB = 1) holds `mem_strobe` for `rom_len_code` + 4 clocks. All codes 0 to 7 are valid, giving 4 to 11 clocks.
- R6: The block samples `req_parity` and `rom_len_code` at acceptance. Changing either one during the access changes neither the access length nor `mem_par_en`.
- R7: A ROM write raises `rsp_err` for one clock, in the clock right after acceptance. It never raises `mem_strobe` or `rsp_ack`.
- R8: `rsp_ack` lasts one clock. In the next clock `req_ready` is high again, and a new request can be accepted.
- R9: While `mem_strobe` is high, `mem_addr`, `mem_we`, `mem_wdata` (32 bits) and `mem_par_en` hold the values latched at acceptance.
- R10: During the ack clock of a read, `rsp_rdata` equals `mem_rdata`. It is zero in every other clock.
- R11: After reset, `req_ready` is high and `mem_strobe`, `rsp_ack` and `rsp_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Access address; MSB set selects ROM |
| req_write | input | 1 | 1 = write, 0 = read |
| req_parity | input | 1 | Parity checking enabled for this access |
| req_wdata | input | 32 | Write data |
| rom_len_code | input | 3 | ROM access length minus 4 |
| mem_strobe | output | 1 | Memory access in progress |
| mem_addr | output | ADDR_W | Latched address |
| mem_we | output | 1 | Latched write flag |
| mem_par_en | output | 1 | Latched parity enable |
| mem_wdata | output | 32 | Latched write data |
| mem_rdata | input | 32 | Read data from memory |
| rsp_ack | output | 1 | Access completed normally |
| rsp_err | output | 1 | ROM write rejected |
| rsp_rdata | output | 32 | Read data, valid while `rsp_ack` is high on a read |

## Verification
The embedded properties check five things on every clock. The ready/strobe exclusion holds. Acknowledge and error last one clock each and never coincide. The latched fields stay stable while the strobe is high. ROM writes produce no strobe. The DRAM access lengths are checked by an independent run counter. Only the bench's scenarios can show the remaining behaviour. The bench sweeps all eight ROM codes under both parity settings, every DRAM direction and parity combination, and ROM writes. In each case it changes the parity input and the code input in the middle of the access, and it holds a competing request against back-pressure. This shows that the length follows the values sampled at acceptance and that the returned read data is routed correctly.

// File: rtl/memcyc_pkg.sv
package memcyc_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic {
    REGION_DRAM = 1'b0,
    REGION_ROM  = 1'b1
  } region_e;
endpackage

// File: rtl/memcyc_len_calc.sv
module memcyc_len_calc
  import memcyc_pkg::*;
#(
  parameter int unsigned CODE_W      = 3,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned ROM_BASE    = 4,
  parameter int unsigned DRAM_WR_LEN = 3,
  parameter int unsigned DRAM_RD_LEN = 5,
  parameter int unsigned PAR_EXTRA   = 1
) (
  input  region_e            region,
  input  logic               write,
  input  logic               parity,
  input  logic [CODE_W-1:0]  rom_code,
  output logic [CNT_W-1:0]   len
);
  localparam logic [CNT_W-1:0] L_WR   = CNT_W'(DRAM_WR_LEN);
  localparam logic [CNT_W-1:0] L_RD   = CNT_W'(DRAM_RD_LEN);
  localparam logic [CNT_W-1:0] L_PAR  = CNT_W'(DRAM_RD_LEN + PAR_EXTRA);
  localparam logic [CNT_W-1:0] L_BASE = CNT_W'(ROM_BASE);

  always_comb begin
    if (region == REGION_ROM) begin
      len = L_BASE + CNT_W'(rom_code);
    end else if (write) begin
      len = L_WR;
    end else if (parity) begin
      len = L_PAR;
    end else begin
      len = L_RD;
    end
  end

  always_comb begin
    assert (len != '0) else $error("p_len_nonzero_r5: zero access length");
  end
endmodule

// File: rtl/memcyc_down_counter.sv
module memcyc_down_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] remain_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
    end else if (load) begin
      busy_q   <= 1'b1;
      remain_q <= load_len - CNT_W'(1);
    end else if (busy_q) begin
      if (remain_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        remain_q <= remain_q - CNT_W'(1);
      end
    end
  end

  assign busy = busy_q;
  assign last = busy_q && (remain_q == '0);

  p_no_reload_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !load);
  p_last_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy_q);
endmodule

// File: rtl/memcyc_timer.sv
module memcyc_timer
  import memcyc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned CODE_W      = 3,
  parameter int unsigned ROM_BASE    = 4,
  parameter int unsigned DRAM_WR_LEN = 3,
  parameter int unsigned DRAM_RD_LEN = 5,
  parameter int unsigned PAR_EXTRA   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_parity,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CODE_W-1:0] rom_len_code,
  output logic              mem_strobe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_par_en,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_ack,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int unsigned MAX_LEN = ROM_BASE + (1 << CODE_W) - 1;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  region_e          req_region;
  logic             accept;
  logic             rom_write;
  logic [CNT_W-1:0] acc_len;
  logic             busy;
  logic             last;
  logic             err_q;
  logic [ADDR_W-1:0] addr_q;
  logic             we_q;
  logic             par_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_region = region_e'(req_addr[ADDR_W-1]);
  assign req_ready  = !busy && !err_q;
  assign accept     = req_valid && req_ready;
  assign rom_write  = (req_region == REGION_ROM) && req_write;

  memcyc_len_calc #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .ROM_BASE(ROM_BASE),
    .DRAM_WR_LEN(DRAM_WR_LEN), .DRAM_RD_LEN(DRAM_RD_LEN), .PAR_EXTRA(PAR_EXTRA)
  ) u_len (
    .region(req_region), .write(req_write), .parity(req_parity),
    .rom_code(rom_len_code), .len(acc_len)
  );

  memcyc_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(accept && !rom_write), .load_len(acc_len),
    .busy(busy), .last(last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      par_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      err_q <= accept && rom_write;
      if (accept) begin
        addr_q  <= req_addr;
        we_q    <= req_write;
        par_q   <= req_parity;
        wdata_q <= req_wdata;
      end
    end
  end

  assign mem_strobe = busy;
  assign mem_addr   = addr_q;
  assign mem_we     = we_q;
  assign mem_par_en = par_q;
  assign mem_wdata  = wdata_q;
  assign rsp_ack    = last;
  assign rsp_err    = err_q;
  assign rsp_rdata  = (last && !we_q) ? mem_rdata : '0;

  // Independent run-length counter used only by the length properties below
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n || accept) run_q <= '0;
    else if (busy)        run_q <= run_q + CNT_W'(1);
  end

  p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_strobe |-> !req_ready);
  p_dram_wr_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack && we_q && !addr_q[ADDR_W-1]) |-> (run_q == CNT_W'(DRAM_WR_LEN - 1)));
  p_dram_rd_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack && !we_q && !par_q && !addr_q[ADDR_W-1]) |-> (run_q == CNT_W'(DRAM_RD_LEN - 1)));
  p_dram_rdp_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack && !we_q && par_q && !addr_q[ADDR_W-1]) |-> (run_q == CNT_W'(DRAM_RD_LEN + PAR_EXTRA - 1)));
  p_err_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (!mem_strobe && !rsp_ack));
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> !rsp_err);
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> (!rsp_ack && req_ready));
  p_hold_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && $past(mem_strobe)) |->
      ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata) && $stable(mem_par_en)));
endmodule

// File: tb/memcyc_timer_test.sv
module memcyc_timer_test;
  localparam int ADDR_W = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic              req_parity = 1'b0;
  logic [31:0]       req_wdata = '0;
  logic [2:0]        rom_len_code = '0;
  logic              mem_strobe;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic              mem_par_en;
  logic [31:0]       mem_wdata;
  logic [31:0]       mem_rdata;
  logic              rsp_ack;
  logic              rsp_err;
  logic [31:0]       rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign mem_rdata = mem_strobe ? {8'hA5, mem_addr} : 32'hDEAD_BEEF;

  memcyc_timer #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_parity(req_parity),
    .req_wdata(req_wdata), .rom_len_code(rom_len_code),
    .mem_strobe(mem_strobe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_par_en(mem_par_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input bit rom, input bit wr, input bit par, input int code);
    if (rom) return code + 4;
    if (wr) return 3;
    return par ? 6 : 5;
  endfunction

  task automatic access(input logic [ADDR_W-1:0] addr, input bit wr, input bit par,
                        input int code, input logic [31:0] wdata, input bit hold);
    bit rom;
    int n;
    int cyc;
    bit saw_ack;
    bit saw_err;
    bit busy_ready;
    rom = addr[ADDR_W-1];
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_addr = addr; req_write = wr; req_parity = par;
    rom_len_code = 3'(code); req_wdata = wdata;
    @(negedge clk);
    // R6: disturb sampled inputs; R1: optionally keep a competing request valid
    req_parity = ~par; rom_len_code = 3'(code + 3);
    req_valid = hold; req_addr = addr ^ 24'h00_0F0F; req_wdata = ~wdata;
    n = 0; cyc = 0; saw_ack = 0; saw_err = 0; busy_ready = 0;
    while (cyc < 20) begin
      cyc++;
      if (mem_strobe) n++;
      if (req_ready) busy_ready = 1;
      if (rsp_ack) begin
        saw_ack = 1;
        check(mem_addr == addr, "R9 address held", mem_addr, addr);
        check(mem_par_en == par, "R6 parity latched", mem_par_en, par);
        if (wr) check(mem_wdata == wdata, "R9 write data held", mem_wdata, wdata);
        else check(rsp_rdata == {8'hA5, addr}, "R10 read data routed", rsp_rdata, {8'hA5, addr});
        break;
      end
      if (rsp_err) begin saw_err = 1; break; end
      check(rsp_rdata == 32'h0, "R10 rdata zero outside ack", rsp_rdata, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(!busy_ready, "R1 ready low while busy", busy_ready, 0);
    if (rom && wr) begin
      check(saw_err && !saw_ack && cyc == 1, "R7 rom write error pulse", {saw_err, saw_ack, 8'(cyc)}, 12'h201);
      check(n == 0, "R7 no strobe on rom write", n, 0);
    end else begin
      check(saw_ack && !saw_err, "R8 ack seen", {saw_ack, saw_err}, 2'b10);
      check(n == exp_len(rom, wr, par, code) && cyc == n,
            rom ? "R5 rom length (R6 sampled code)" :
            wr ? "R2 dram write length" : par ? "R4 dram parity read length" : "R3 dram read length",
            n, exp_len(rom, wr, par, code));
    end
    @(negedge clk);
    check(req_ready && !rsp_ack && !rsp_err && !mem_strobe, "R8 single pulse then ready",
          {req_ready, rsp_ack, rsp_err, mem_strobe}, 4'b1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !mem_strobe && !rsp_ack && !rsp_err, "R11 reset state",
          {req_ready, mem_strobe, rsp_ack, rsp_err}, 4'b1000);
    rst_n = 1'b1;
    for (int code = 0; code < 8; code++)
      for (int par = 0; par < 2; par++)
        access(24'h80_0000 + 24'(code * 16 + par), 1'b0, par[0], code, 32'h0, code[0]);
    for (int wr = 0; wr < 2; wr++)
      for (int par = 0; par < 2; par++)
        for (int hold = 0; hold < 2; hold++)
          access(24'h01_2340 + 24'(wr * 4 + par * 2 + hold), wr[0], par[0], 7,
                 32'hC0DE_0000 + 32'(wr * 16 + par), hold[0]);
    for (int code = 0; code < 8; code += 7)
      access(24'h80_1000 + 24'(code), 1'b1, 1'b1, code, 32'h1234_5678, 1'b1);
    access(24'h00_0044, 1'b0, 1'b1, 0, 32'h0, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule